// File: doc/BRIEF.md
# AXI Transaction ID Compaction Mapper

This block sits between an interconnect and a coherency slave port that accepts only 3-bit transaction IDs. The masters upstream carry 12-bit IDs. For every address-channel request the block picks one of six output IDs (2 to 7). The choice comes from a per-slot fixed mapping or from a shared dynamic pool that is handed out first-come, first-served. The block also places a 2-bit page above a 30-bit offset, which selects one of four 1 GiB windows, and it supplies a 5-bit user sideband value. On the response side it turns the 3-bit ID back into the original 12-bit ID.

The read channel is index 0 of every per-channel port and the write channel is index 1. Each channel has its own table. A dynamic output ID stays bound to its input ID while that ID has transactions outstanding. The binding is freed when the last outstanding response completes. A request that cannot be mapped is stalled by holding its ready low.

Configuration arrives on a single write port.
- With `cfg_shared`=1, the write sets the channel's shared dynamic page and user value.
- Otherwise it writes slot `cfg_oid`: the mode bit (`cfg_fixed`), the input ID, the page and the user value.

Top module: `axi_id_compactor`

## Requirements
- R1: After reset, output ID 2 of each channel is a fixed mapping for input ID 0x004 with page 0 and user 0. Output IDs 3 to 7 are dynamic, and the shared dynamic page and user are both 0.
- R2: A request whose ID equals the input ID of a fixed slot is issued with that slot's output ID, page and user value.
- R3: A request with no fixed match and no live binding gets the lowest-numbered free dynamic output ID. A dynamic slot is free when it has zero transactions outstanding. The request uses the channel's shared page and user.
- R4: A request whose ID matches a dynamic slot with outstanding transactions reuses that slot's output ID, and the slot's outstanding count rises by one.
- R5: A response with `rsp_valid`=1 and `rsp_last`=1 on a dynamic output ID lowers its count by one. At zero the slot becomes free for any input ID.
- R6: When a request has no fixed match, no binding and no free slot, or when its binding's counter is saturated, `out_valid` and `req_ready` stay 0. `req_ready` is 1 only when `out_valid` and `out_ready` are both 1.
- R7: A request whose ID has bit 11 = 0 and bits [2:0] = 0 keeps its own `req_user` value on `out_user`, whatever user value is configured.
- R8: `rsp_orig_id` gives the 12-bit ID behind `rsp_id`: the configured input ID for a fixed slot, the bound ID for a dynamic slot, and 0 for output IDs 0 and 1.
- R9: Configuration writes to output IDs 0 and 1 are ignored. A fixed-mode write to output ID 7 leaves it dynamic.
- R10: The read and write channels keep separate tables, and configuring one leaves the other's mapping unchanged.
- R11: An accepted request and a final response on the same dynamic slot in the same cycle leave its count unchanged, so the binding survives.
- R12: `out_addr` equals {page, `req_ofs`}, with the page in bits [31:30].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_valid | input | 1 | Configuration write strobe |
| cfg_chan | input | 1 | Target channel: 0 read, 1 write |
| cfg_shared | input | 1 | 1: write shared dynamic page/user; 0: write a slot |
| cfg_oid | input | 3 | Target output ID for a slot write |
| cfg_fixed | input | 1 | Slot mode: 1 fixed, 0 dynamic |
| cfg_in_id | input | 12 | Input ID for a fixed slot |
| cfg_page | input | 2 | Page value |
| cfg_user | input | 5 | User sideband value |
| req_valid | input | 2 | Request valid per channel |
| req_id | input | 2x12 | Incoming transaction ID per channel |
| req_ofs | input | 2x30 | Offset inside the 1 GiB window |
| req_user | input | 2x5 | Incoming user sideband |
| req_ready | output | 2 | Request accepted |
| out_valid | output | 2 | Mapped request valid |
| out_ready | input | 2 | Slave port ready |
| out_id | output | 2x3 | Mapped output ID |
| out_addr | output | 2x32 | Page and offset |
| out_user | output | 2x5 | Outgoing user sideband |
| rsp_valid | input | 2 | Response beat valid |
| rsp_id | input | 2x3 | Response output ID |
| rsp_last | input | 2 | Final beat of a transaction |
| rsp_orig_id | output | 2x12 | Restored 12-bit ID |

## Verification
The functions that can coincide are request acceptance and binding release on the same dynamic slot in the same cycle. The bench creates this case by leaving one transaction outstanding on a bound slot. In a single cycle it then issues a new request with the same ID and drives the final response for that slot. The result is judged at the ports in two steps. First, a request with a different unmapped ID must still stall, because the slot is still held. Second, after one more final response, that same request must receive the slot.

// File: rtl/idc_pkg.sv
package idc_pkg;
    localparam int IN_W      = 12;
    localparam int OUT_W     = 3;
    localparam int PAGE_W    = 2;
    localparam int USER_W    = 5;
    localparam int OFS_W     = 30;
    localparam int ADDR_W    = PAGE_W + OFS_W;
    localparam int FIRST_OID = 2;
    localparam int LAST_OID  = 7;
    localparam int NSLOT     = LAST_OID - FIRST_OID + 1;
    localparam int NCH       = 2;
    localparam logic [IN_W-1:0] DBG_ID = 12'h004;

    typedef struct packed {
        logic              fixed;
        logic [IN_W-1:0]   in_id;
        logic [PAGE_W-1:0] page;
        logic [USER_W-1:0] user;
    } slot_cfg_t;

    // Masters of the bridge class drive their own sideband value.
    function automatic logic is_bridge(input logic [IN_W-1:0] id);
        return !id[IN_W-1] && (id[2:0] == 3'd0);
    endfunction

    // Index of the lowest set bit, 0 when none.
    function automatic logic [OUT_W-1:0] first_set(input logic [NSLOT-1:0] v);
        logic [OUT_W-1:0] r;
        r = '0;
        for (int i = NSLOT - 1; i >= 0; i--)
            if (v[i]) r = OUT_W'(i);
        return r;
    endfunction
endpackage

// File: rtl/idc_slot.sv
module idc_slot
    import idc_pkg::*;
#(
    parameter int OID   = 2,
    parameter int CNT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_fixed,
    input  logic [IN_W-1:0]   cfg_in_id,
    input  logic [PAGE_W-1:0] cfg_page,
    input  logic [USER_W-1:0] cfg_user,
    input  logic              inc,
    input  logic [IN_W-1:0]   inc_id,
    input  logic              dec,
    output slot_cfg_t         cfg_q,
    output logic [IN_W-1:0]   bound_id,
    output logic              busy,
    output logic              full
);
    localparam bit FIX_OK    = (OID != LAST_OID);
    localparam bit RST_FIXED = (OID == FIRST_OID);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.fixed <= RST_FIXED;
            cfg_q.in_id <= RST_FIXED ? DBG_ID : '0;
            cfg_q.page  <= '0;
            cfg_q.user  <= '0;
            cnt_q       <= '0;
            bound_id    <= '0;
        end else begin
            if (cfg_we) begin
                cfg_q.fixed <= FIX_OK && cfg_fixed;
                cfg_q.in_id <= cfg_in_id;
                cfg_q.page  <= cfg_page;
                cfg_q.user  <= cfg_user;
            end
            if (inc && !dec)
                cnt_q <= cnt_q + 1'b1;
            else if (!inc && dec && cnt_q != '0)
                cnt_q <= cnt_q - 1'b1;
            if (inc)
                bound_id <= inc_id;
        end
    end

    assign busy = (cnt_q != '0);
    assign full = (cnt_q == '1);

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
        (inc && !dec) |-> !full);
    p_bind_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (busy && !inc) |=> $stable(bound_id));
    p_release_r5: assert property (@(posedge clk) disable iff (rst)
        (dec && !inc && cnt_q == CNT_W'(1)) |=> !busy);
endmodule

// File: rtl/idc_channel.sv
module idc_channel
    import idc_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_shared,
    input  logic [OUT_W-1:0]  cfg_oid,
    input  logic              cfg_fixed,
    input  logic [IN_W-1:0]   cfg_in_id,
    input  logic [PAGE_W-1:0] cfg_page,
    input  logic [USER_W-1:0] cfg_user,
    input  logic              req_valid,
    input  logic [IN_W-1:0]   req_id,
    input  logic [OFS_W-1:0]  req_ofs,
    input  logic [USER_W-1:0] req_user,
    output logic              req_ready,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [OUT_W-1:0]  out_id,
    output logic [ADDR_W-1:0] out_addr,
    output logic [USER_W-1:0] out_user,
    input  logic              rsp_valid,
    input  logic [OUT_W-1:0]  rsp_id,
    input  logic              rsp_last,
    output logic [IN_W-1:0]   rsp_orig_id
);
    slot_cfg_t         cfg_q   [NSLOT];
    logic [IN_W-1:0]   bnd_q   [NSLOT];
    logic [NSLOT-1:0]  busy, full, fix_hit, bnd_hit, free_v, inc, dec;
    logic [PAGE_W-1:0] sh_page;
    logic [USER_W-1:0] sh_user;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_page <= '0;
            sh_user <= '0;
        end else if (cfg_we && cfg_shared) begin
            sh_page <= cfg_page;
            sh_user <= cfg_user;
        end
    end

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        localparam logic [OUT_W-1:0] MY_OID = OUT_W'(FIRST_OID + i);
        idc_slot #(.OID(FIRST_OID + i), .CNT_W(CNT_W)) u_slot (
            .clk      (clk),
            .rst      (rst),
            .cfg_we   (cfg_we && !cfg_shared && cfg_oid == MY_OID),
            .cfg_fixed(cfg_fixed),
            .cfg_in_id(cfg_in_id),
            .cfg_page (cfg_page),
            .cfg_user (cfg_user),
            .inc      (inc[i]),
            .inc_id   (req_id),
            .dec      (dec[i]),
            .cfg_q    (cfg_q[i]),
            .bound_id (bnd_q[i]),
            .busy     (busy[i]),
            .full     (full[i])
        );
        assign fix_hit[i] = cfg_q[i].fixed && cfg_q[i].in_id == req_id;
        assign bnd_hit[i] = !cfg_q[i].fixed && busy[i] && bnd_q[i] == req_id;
        assign free_v[i]  = !cfg_q[i].fixed && !busy[i];
        assign dec[i]     = rsp_valid && rsp_last && rsp_id == MY_OID && !cfg_q[i].fixed;
    end

    logic [OUT_W-1:0] sel;
    logic             found, dyn;
    slot_cfg_t        sel_cfg;
    logic             sel_full;

    always_comb begin
        sel   = '0;
        found = 1'b0;
        dyn   = 1'b0;
        if (|fix_hit) begin
            sel   = first_set(fix_hit);
            found = 1'b1;
        end else if (|bnd_hit) begin
            sel   = first_set(bnd_hit);
            found = 1'b1;
            dyn   = 1'b1;
        end else if (|free_v) begin
            sel   = first_set(free_v);
            found = 1'b1;
            dyn   = 1'b1;
        end
        sel_cfg  = cfg_q[0];
        sel_full = full[0];
        for (int i = 0; i < NSLOT; i++)
            if (sel == OUT_W'(i)) begin
                sel_cfg  = cfg_q[i];
                sel_full = full[i];
            end
    end

    logic [PAGE_W-1:0] pg;
    assign pg        = dyn ? sh_page : sel_cfg.page;
    assign out_valid = req_valid && found && !(dyn && sel_full);
    assign req_ready = out_valid && out_ready;
    assign out_id    = sel + OUT_W'(FIRST_OID);
    assign out_addr  = {pg, req_ofs};
    assign out_user  = is_bridge(req_id) ? req_user : (dyn ? sh_user : sel_cfg.user);

    always_comb
        for (int i = 0; i < NSLOT; i++)
            inc[i] = req_ready && dyn && sel == OUT_W'(i);

    always_comb begin
        rsp_orig_id = '0;
        for (int i = 0; i < NSLOT; i++)
            if (rsp_id == OUT_W'(FIRST_OID + i))
                rsp_orig_id = cfg_q[i].fixed ? cfg_q[i].in_id : bnd_q[i];
    end

    p_no_reserved_r9: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_id >= OUT_W'(FIRST_OID));
    p_single_bind_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(inc));
    p_ready_gate_r6: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (out_ready && req_valid));
endmodule

// File: rtl/axi_id_compactor.sv
module axi_id_compactor
    import idc_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cfg_valid,
    input  logic                          cfg_chan,
    input  logic                          cfg_shared,
    input  logic [OUT_W-1:0]              cfg_oid,
    input  logic                          cfg_fixed,
    input  logic [IN_W-1:0]               cfg_in_id,
    input  logic [PAGE_W-1:0]             cfg_page,
    input  logic [USER_W-1:0]             cfg_user,
    input  logic [NCH-1:0]                req_valid,
    input  logic [NCH-1:0][IN_W-1:0]      req_id,
    input  logic [NCH-1:0][OFS_W-1:0]     req_ofs,
    input  logic [NCH-1:0][USER_W-1:0]    req_user,
    output logic [NCH-1:0]                req_ready,
    output logic [NCH-1:0]                out_valid,
    input  logic [NCH-1:0]                out_ready,
    output logic [NCH-1:0][OUT_W-1:0]     out_id,
    output logic [NCH-1:0][ADDR_W-1:0]    out_addr,
    output logic [NCH-1:0][USER_W-1:0]    out_user,
    input  logic [NCH-1:0]                rsp_valid,
    input  logic [NCH-1:0][OUT_W-1:0]     rsp_id,
    input  logic [NCH-1:0]                rsp_last,
    output logic [NCH-1:0][IN_W-1:0]      rsp_orig_id
);
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        idc_channel #(.CNT_W(CNT_W)) u_ch (
            .clk        (clk),
            .rst        (rst),
            .cfg_we     (cfg_valid && cfg_chan == 1'(c)),
            .cfg_shared (cfg_shared),
            .cfg_oid    (cfg_oid),
            .cfg_fixed  (cfg_fixed),
            .cfg_in_id  (cfg_in_id),
            .cfg_page   (cfg_page),
            .cfg_user   (cfg_user),
            .req_valid  (req_valid[c]),
            .req_id     (req_id[c]),
            .req_ofs    (req_ofs[c]),
            .req_user   (req_user[c]),
            .req_ready  (req_ready[c]),
            .out_valid  (out_valid[c]),
            .out_ready  (out_ready[c]),
            .out_id     (out_id[c]),
            .out_addr   (out_addr[c]),
            .out_user   (out_user[c]),
            .rsp_valid  (rsp_valid[c]),
            .rsp_id     (rsp_id[c]),
            .rsp_last   (rsp_last[c]),
            .rsp_orig_id(rsp_orig_id[c])
        );
    end
endmodule

// File: tb/tb_axi_id_compactor.sv
module tb_axi_id_compactor;
    import idc_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic                       cfg_valid, cfg_chan, cfg_shared, cfg_fixed;
    logic [OUT_W-1:0]           cfg_oid;
    logic [IN_W-1:0]            cfg_in_id;
    logic [PAGE_W-1:0]          cfg_page;
    logic [USER_W-1:0]          cfg_user;
    logic [NCH-1:0]             req_valid, req_ready, out_valid, out_ready;
    logic [NCH-1:0][IN_W-1:0]   req_id;
    logic [NCH-1:0][OFS_W-1:0]  req_ofs;
    logic [NCH-1:0][USER_W-1:0] req_user, out_user;
    logic [NCH-1:0][OUT_W-1:0]  out_id, rsp_id;
    logic [NCH-1:0][ADDR_W-1:0] out_addr;
    logic [NCH-1:0]             rsp_valid, rsp_last;
    logic [NCH-1:0][IN_W-1:0]   rsp_orig_id;

    axi_id_compactor dut (.*);

    localparam logic [OFS_W-1:0] OFS = 30'h0ABC_DEF0;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    typedef struct packed {
        logic              ch;
        logic [IN_W-1:0]   id;
        logic [USER_W-1:0] user;
        logic [OUT_W-1:0]  oid;
        logic [PAGE_W-1:0] page;
        logic [USER_W-1:0] euser;
    } vec_t;

    // Applied in order with acceptance; each entry stays outstanding.
    localparam vec_t VEC [8] = '{
        '{1'b0, 12'h004, 5'h1F, 3'd2, 2'd0, 5'd0},  // R2 fixed reset slot
        '{1'b0, 12'h123, 5'h00, 3'd3, 2'd1, 5'd9},  // R2 programmed fixed slot
        '{1'b0, 12'h801, 5'h00, 3'd4, 2'd2, 5'd5},  // R3 first free
        '{1'b0, 12'h802, 5'h00, 3'd5, 2'd2, 5'd5},  // R3 next free
        '{1'b0, 12'h801, 5'h00, 3'd4, 2'd2, 5'd5},  // R4 reuse binding
        '{1'b0, 12'h010, 5'h0A, 3'd6, 2'd2, 5'h0A}, // R7 bridge class
        '{1'b0, 12'h805, 5'h00, 3'd7, 2'd2, 5'd5},  // R3 slot 7 dynamic
        '{1'b1, 12'h801, 5'h00, 3'd3, 2'd0, 5'd0}   // R10 write channel defaults
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic clear();
        cfg_valid = 0; cfg_chan = 0; cfg_shared = 0; cfg_fixed = 0;
        cfg_oid = '0; cfg_in_id = '0; cfg_page = '0; cfg_user = '0;
        req_valid = '0; req_id = '0; req_ofs = '0; req_user = '0;
        out_ready = '0; rsp_valid = '0; rsp_id = '0; rsp_last = '0;
    endtask

    task automatic tick();
        @(posedge clk);
    endtask

    task automatic cfg(input logic ch, input logic sh, input logic [2:0] oid, input logic fx,
                       input logic [11:0] id, input logic [1:0] pg, input logic [4:0] us);
        @(negedge clk);
        clear();
        cfg_valid = 1; cfg_chan = ch; cfg_shared = sh; cfg_oid = oid; cfg_fixed = fx;
        cfg_in_id = id; cfg_page = pg; cfg_user = us;
        tick();
    endtask

    // Drive a request and optionally a final response, then settle.
    task automatic drive(input logic ch, input logic rq, input logic [11:0] id, input logic [4:0] us,
                         input logic acc, input logic rs, input logic [2:0] rid);
        @(negedge clk);
        clear();
        req_valid[ch] = rq; req_id[ch] = id; req_user[ch] = us; req_ofs[ch] = OFS;
        out_ready[ch] = acc;
        rsp_valid[ch] = rs; rsp_id[ch] = rid; rsp_last[ch] = rs;
        #1;
    endtask

    task automatic chk_out(input logic ch, input string tag, input logic ev, input logic [2:0] eo,
                           input logic [1:0] ep, input logic [4:0] eu);
        chk(out_valid[ch] == ev, {tag, " valid"}, 32'(out_valid[ch]), 32'(ev));
        if (ev) begin
            chk(out_id[ch] == eo, {tag, " id"}, 32'(out_id[ch]), 32'(eo));
            chk(out_addr[ch] == {ep, OFS}, {tag, " addr R12"}, out_addr[ch], {ep, OFS});
            chk(out_user[ch] == eu, {tag, " user"}, 32'(out_user[ch]), 32'(eu));
        end else begin
            chk(req_ready[ch] == 1'b0, {tag, " ready"}, 32'(req_ready[ch]), 32'd0);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        clear();
        repeat (3) tick();
        @(negedge clk);
        rst = 0;

        // R1 reset state, observed without acceptance
        drive(0, 1, 12'h004, 5'h1F, 0, 0, 0);
        chk_out(0, "R1 fixed debug slot", 1, 2, 0, 0);
        chk(req_ready[0] == 0, "R6 ready without out_ready", 32'(req_ready[0]), 0);
        tick();
        drive(0, 1, 12'h777, 5'h03, 0, 0, 0);
        chk_out(0, "R1 dynamic default", 1, 3, 0, 0);
        tick();

        cfg(0, 1, 0, 0, 12'h000, 2, 5);        // read shared page 2 user 5
        cfg(0, 0, 3, 1, 12'h123, 1, 9);        // read slot 3 fixed
        cfg(1, 0, 7, 1, 12'h333, 3, 2);        // R9 fixed on 7 refused
        cfg(1, 0, 0, 1, 12'h444, 3, 1);        // R9 reserved slot ignored

        for (int v = 0; v < 8; v++) begin
            drive(VEC[v].ch, 1, VEC[v].id, VEC[v].user, 1, 0, 0);
            chk_out(VEC[v].ch, $sformatf("vector %0d R2 R3 R4 R7 R10", v), 1,
                    VEC[v].oid, VEC[v].page, VEC[v].euser);
            chk(req_ready[VEC[v].ch] == 1, "R6 ready on accept", 32'(req_ready[VEC[v].ch]), 1);
            tick();
        end

        // R6 pool exhausted
        drive(0, 1, 12'h806, 0, 1, 0, 0);
        chk_out(0, "R6 stall full pool", 0, 0, 0, 0);
        tick();
        // R8 restore, first of two completions on slot 4
        drive(0, 0, 0, 0, 0, 1, 4);
        chk(rsp_orig_id[0] == 12'h801, "R8 restore dynamic", 32'(rsp_orig_id[0]), 32'h801);
        tick();
        drive(0, 1, 12'h806, 0, 1, 0, 0);
        chk_out(0, "R5 still held", 0, 0, 0, 0);
        tick();
        drive(0, 0, 0, 0, 0, 1, 4);
        tick();
        drive(0, 1, 12'h806, 0, 1, 0, 0);
        chk_out(0, "R5 released slot reused", 1, 4, 2, 5);
        tick();

        // R11 accept and release on slot 5 in one cycle
        drive(0, 1, 12'h802, 0, 1, 1, 5);
        chk_out(0, "R11 same-cycle accept", 1, 5, 2, 5);
        tick();
        drive(0, 1, 12'h900, 0, 1, 0, 0);
        chk_out(0, "R11 binding survives", 0, 0, 0, 0);
        tick();
        drive(0, 0, 0, 0, 0, 1, 5);
        chk(rsp_orig_id[0] == 12'h802, "R8 R11 restore", 32'(rsp_orig_id[0]), 32'h802);
        tick();
        drive(0, 1, 12'h900, 0, 1, 0, 0);
        chk_out(0, "R11 freed after last", 1, 5, 2, 5);
        tick();

        // R8 fixed restore and reserved IDs
        drive(0, 0, 0, 0, 0, 1, 3);
        chk(rsp_orig_id[0] == 12'h123, "R8 restore fixed", 32'(rsp_orig_id[0]), 32'h123);
        tick();
        drive(0, 0, 0, 0, 0, 1, 1);
        chk(rsp_orig_id[0] == 12'h000, "R8 reserved id", 32'(rsp_orig_id[0]), 0);
        tick();

        // R9 on the write channel
        drive(1, 1, 12'h444, 0, 1, 0, 0);
        chk_out(1, "R9 reserved write ignored", 1, 4, 0, 0);
        tick();
        drive(1, 1, 12'h333, 0, 1, 0, 0);
        chk_out(1, "R9 slot 7 not fixed", 1, 5, 0, 0);
        tick();
        drive(1, 1, 12'h555, 0, 1, 0, 0);
        chk_out(1, "R3 write next free", 1, 6, 0, 0);
        tick();
        drive(1, 1, 12'h556, 5'd3, 1, 0, 0);
        chk_out(1, "R9 slot 7 dynamic", 1, 7, 0, 0);
        tick();

        @(negedge clk);
        clear();
        finish_run();
    end
endmodule